// File: doc/BRIEF.md
# Programmable Counter/Timer with Clock-Source Select

This block is the 16-bit down-counting counter/timer of a dual-channel serial controller. A 3-bit mode field picks both the operating style and the clock that advances the count. In counter style the count moves only between software start and stop commands, and a ready flag reports the terminal count. In timer style the count runs freely, reloads itself at terminal count and drives a square-wave output. Every clock source reaches the block as a one-cycle enable strobe in the system clock domain. The sources are an external input pin, the 1X transmit clocks of the two channels, and the reference crystal clock (nominally 3.6864 MHz). Two free-running divide-by-16 prescalers provide slowed versions of the pin strobe and of the crystal strobe.

Software writes a 16-bit preload value as two bytes. A preload of zero stands for 65536 source ticks.

Top module: `ctmr_top`

## Requirements
- R1: After synchronous reset the count is 0x0000, the preload is zero, and both ready and the square-wave output are 0.
- R2: A write on the high-byte strobe sets preload[15:8] and a write on the low-byte strobe sets preload[7:0]. A preload of 0x0000 gives a terminal count after 65536 ticks.
- R3: A start command loads the count from the preload one cycle later. In counter style (mode bit 2 = 0) the count falls by one per selected tick only after a start and before a stop. A stopped count holds its value.
- R4: A counter-style tick at count 1 sets ready and moves the count to 0x0000. The next tick wraps the count to 0xFFFF and counting continues.
- R5: A stop command clears ready one cycle later. A stop wins over a start or a terminal count that falls in the same cycle.
- R6: In timer style (mode bit 2 = 1) the count runs without a start. A tick at count 1 reloads the preload, toggles the square-wave output and sets ready, so a preload P gives an output period of 2P ticks. A start restarts the count and clears the output to 0. In counter style the output does not change.
- R7: The counter-style sources are: mode 000 the external pin strobe, mode 001 the channel A transmit 1X strobe, mode 010 the channel B transmit 1X strobe, and mode 011 the crystal strobe divided by 16. Strobes from unselected sources have no effect.
- R8: The timer-style sources are: mode 100 the external pin strobe, mode 101 the pin strobe divided by 16, mode 110 the undivided crystal strobe, and mode 111 the crystal strobe divided by 16.
- R9: Each divide-by-16 path counts its own strobes from reset. It yields one tick on every 16th strobe, in the same cycle as that strobe.
- R10: A start that falls in the same cycle as a selected tick loads the preload. The tick does not decrement the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Style and clock-source selection field |
| pin_stb | input | 1 | External input pin enable strobe |
| txa_stb | input | 1 | Channel A transmitter 1X clock strobe |
| txb_stb | input | 1 | Channel B transmitter 1X clock strobe |
| xtal_stb | input | 1 | Reference crystal clock strobe |
| pre_hi_we | input | 1 | Write wdata into preload high byte |
| pre_lo_we | input | 1 | Write wdata into preload low byte |
| wdata | input | 8 | Preload byte data |
| start_cmd | input | 1 | Start / reload command |
| stop_cmd | input | 1 | Stop command, clears ready |
| count_val | output | 16 | Current count |
| ready | output | 1 | Terminal-count flag |
| sq_out | output | 1 | Timer square-wave output |

## Verification
Two events can fall in the same cycle: a software command and a source tick.

The first collision pairs a stop command with the tick that reaches terminal count. The bench drives both on one edge. It expects the count to reach zero while ready stays low.

The second collision pairs a start command with a selected tick. Here the count must equal the preload rather than the preload minus one.

The prescaler phase is pinned by a fresh reset before each divided-source scenario. This lets the exact 16th-strobe tick be told apart from an off-by-one tick.

// File: rtl/ct_pkg.sv
package ct_pkg;
    localparam int CT_W     = 16;
    localparam int PRE_BITS = 4;

    typedef enum logic [2:0] {
        CM_PIN   = 3'b000,
        CM_TXA   = 3'b001,
        CM_TXB   = 3'b010,
        CM_XDIV  = 3'b011,
        TM_PIN   = 3'b100,
        TM_PDIV  = 3'b101,
        TM_XTAL  = 3'b110,
        TM_XDIV  = 3'b111
    } ct_mode_e;

    typedef struct packed {
        logic pin;
        logic pin_div;
        logic txa;
        logic txb;
        logic xtal;
        logic xtal_div;
    } ct_src_s;

    function automatic logic is_timer(input ct_mode_e m);
        return m[2];
    endfunction
endpackage

// File: rtl/ct_prescale16.sv
module ct_prescale16 #(
    parameter int BITS = ct_pkg::PRE_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_in,
    output logic stb_out
);
    localparam logic [BITS-1:0] LAST = '1;

    logic [BITS-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= '0;
        else if (stb_in) phase_q <= phase_q + 1'b1;
    end

    assign stb_out = stb_in && (phase_q == LAST);

    // R9: after a divided tick the phase restarts, so two ticks never touch
    p_spaced_ticks_r9: assert property (@(posedge clk) disable iff (rst)
        stb_out |=> !stb_out);
endmodule

// File: rtl/ct_src_mux.sv
module ct_src_mux
    import ct_pkg::*;
(
    input  ct_mode_e mode,
    input  ct_src_s  src,
    output logic     tick
);
    always_comb begin
        unique case (mode)
            CM_PIN:  tick = src.pin;
            CM_TXA:  tick = src.txa;
            CM_TXB:  tick = src.txb;
            CM_XDIV: tick = src.xtal_div;
            TM_PIN:  tick = src.pin;
            TM_PDIV: tick = src.pin_div;
            TM_XTAL: tick = src.xtal;
            TM_XDIV: tick = src.xtal_div;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ct_core.sv
module ct_core
    import ct_pkg::*;
#(
    parameter int W = CT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ct_mode_e     mode,
    input  logic         tick,
    input  logic         pre_hi_we,
    input  logic         pre_lo_we,
    input  logic [7:0]   wdata,
    input  logic         start_cmd,
    input  logic         stop_cmd,
    output logic [W-1:0] count,
    output logic         ready,
    output logic         sq
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] preload_q;
    logic         running_q;
    logic         do_start;
    logic         active;
    logic         terminal;
    logic         timer;

    assign timer    = is_timer(mode);
    assign do_start = start_cmd && !stop_cmd;
    assign active   = timer || running_q;
    assign terminal = active && tick && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q <= '0;
        end else begin
            if (pre_hi_we) preload_q[W-1:HALF] <= wdata;
            if (pre_lo_we) preload_q[HALF-1:0] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            running_q <= 1'b0;
            ready     <= 1'b0;
            sq        <= 1'b0;
        end else begin
            if (stop_cmd)      running_q <= 1'b0;
            else if (do_start) running_q <= 1'b1;

            if (do_start)                count <= preload_q;
            else if (terminal)           count <= timer ? preload_q : '0;
            else if (active && tick)     count <= count - 1'b1;

            if (stop_cmd)                ready <= 1'b0;
            else if (terminal && !do_start) ready <= 1'b1;

            if (do_start)                sq <= 1'b0;
            else if (terminal && timer)  sq <= ~sq;
        end
    end

    // R5: stop always leaves ready low on the next cycle
    p_stop_clears_ready_r5: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> !ready);
    // R3: start loads the preload register value
    p_start_loads_r3: assert property (@(posedge clk) disable iff (rst)
        (start_cmd && !stop_cmd) |=> (count == $past(preload_q)));
    // R3: idle counter style holds the count
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!timer && !running_q && !start_cmd) |=> $stable(count));
    // R4: ready only rises out of a count of one
    p_ready_from_one_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(count) == ONE));
    // R6: the square wave is still in counter style
    p_sq_still_counter_r6: assert property (@(posedge clk) disable iff (rst)
        (!timer && !start_cmd) |=> $stable(sq));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ct_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode_sel,
    input  logic        pin_stb,
    input  logic        txa_stb,
    input  logic        txb_stb,
    input  logic        xtal_stb,
    input  logic        pre_hi_we,
    input  logic        pre_lo_we,
    input  logic [7:0]  wdata,
    input  logic        start_cmd,
    input  logic        stop_cmd,
    output logic [15:0] count_val,
    output logic        ready,
    output logic        sq_out
);
    localparam int NDIV = 2;

    ct_mode_e mode;
    ct_src_s  src;
    logic     tick;
    logic [NDIV-1:0] div_in;
    logic [NDIV-1:0] div_out;

    assign mode   = ct_mode_e'(mode_sel);
    assign div_in = {pin_stb, xtal_stb};

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        ct_prescale16 #(.BITS(PRE_BITS)) u_div (
            .clk     (clk),
            .rst     (rst),
            .stb_in  (div_in[g]),
            .stb_out (div_out[g])
        );
    end

    always_comb begin
        src.pin      = pin_stb;
        src.pin_div  = div_out[1];
        src.txa      = txa_stb;
        src.txb      = txb_stb;
        src.xtal     = xtal_stb;
        src.xtal_div = div_out[0];
    end

    ct_src_mux u_mux (
        .mode (mode),
        .src  (src),
        .tick (tick)
    );

    ct_core #(.W(CT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .tick      (tick),
        .pre_hi_we (pre_hi_we),
        .pre_lo_we (pre_lo_we),
        .wdata     (wdata),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .count     (count_val),
        .ready     (ready),
        .sq        (sq_out)
    );
endmodule

// File: tb/test_ctmr_top.sv
module test_ctmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        pin_stb = 0, txa_stb = 0, txb_stb = 0, xtal_stb = 0;
    logic        pre_hi_we = 0, pre_lo_we = 0;
    logic [7:0]  wdata = 8'h00;
    logic        start_cmd = 0, stop_cmd = 0;
    logic [15:0] count_val;
    logic        ready, sq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10ns clk = ~clk;

    ctmr_top i_ctmr_top (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .pin_stb(pin_stb), .txa_stb(txa_stb), .txb_stb(txb_stb), .xtal_stb(xtal_stb),
        .pre_hi_we(pre_hi_we), .pre_lo_we(pre_lo_we), .wdata(wdata),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .count_val(count_val), .ready(ready), .sq_out(sq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        cyc(2); rst = 1'b0;
    endtask

    task automatic write_pre(input logic [15:0] v);
        @(negedge clk);
        pre_hi_we = 1; wdata = v[15:8];
        @(negedge clk);
        pre_hi_we = 0; pre_lo_we = 1; wdata = v[7:0];
        @(negedge clk);
        pre_lo_we = 0;
    endtask

    task automatic cmd(input bit st, input bit sp);
        start_cmd = st; stop_cmd = sp;
        @(negedge clk);
        start_cmd = 0; stop_cmd = 0;
    endtask

    // 0 pin, 1 txa, 2 txb, 3 xtal ; strobe held for n cycles
    task automatic strobe(input int which, input int n);
        case (which)
            0: pin_stb = 1; 1: txa_stb = 1; 2: txb_stb = 1; default: xtal_stb = 1;
        endcase
        cyc(n);
        pin_stb = 0; txa_stb = 0; txb_stb = 0; xtal_stb = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count_val, 0);
        check("R1 ready", ready, 0);
        check("R1 sq", sq_out, 0);
    endtask

    task automatic t_counter_txa();
        do_reset();
        mode_sel = 3'b001;
        write_pre(16'h1234);
        cmd(1, 0);
        check("R2 bytes", count_val, 16'h1234);
        write_pre(16'd5);
        cmd(1, 0);
        check("R3 start load", count_val, 5);
        strobe(1, 3);
        check("R3 decrement", count_val, 2);
        strobe(0, 2); strobe(2, 2); strobe(3, 20);
        check("R7 unselected ignored", count_val, 2);
        cmd(0, 1);
        strobe(1, 2);
        check("R3 stopped holds", count_val, 2);
        cmd(1, 0);
        strobe(1, 4);
        check("R4 at one", count_val, 1);
        check("R4 ready low", ready, 0);
        strobe(1, 1);
        check("R4 terminal zero", count_val, 0);
        check("R4 ready set", ready, 1);
        check("R6 sq still counter", sq_out, 0);
        strobe(1, 1);
        check("R4 wrap", count_val, 16'hFFFF);
        cmd(0, 1);
        check("R5 stop clears", ready, 0);
    endtask

    task automatic t_counter_other();
        do_reset();
        write_pre(16'd9);
        mode_sel = 3'b000;
        cmd(1, 0);
        strobe(1, 1); strobe(0, 1);
        check("R7 mode000 pin", count_val, 8);
        mode_sel = 3'b010;
        strobe(0, 1); strobe(2, 2);
        check("R7 mode010 txb", count_val, 6);
    endtask

    task automatic t_counter_xdiv();
        do_reset();
        mode_sel = 3'b011;
        write_pre(16'd100);
        cmd(1, 0);
        strobe(3, 15);
        check("R9 15 strobes no tick", count_val, 100);
        strobe(3, 1);
        check("R7 R9 16th strobe", count_val, 99);
        strobe(3, 16);
        check("R9 next 16", count_val, 98);
    endtask

    task automatic t_timer_xtal();
        do_reset();
        mode_sel = 3'b110;
        write_pre(16'd3);
        cmd(1, 0);
        check("R6 start clears sq", sq_out, 0);
        strobe(3, 2);
        check("R8 mode110 xtal", count_val, 1);
        strobe(3, 1);
        check("R6 reload", count_val, 3);
        check("R6 toggle high", sq_out, 1);
        check("R6 ready", ready, 1);
        strobe(3, 3);
        check("R6 toggle low", sq_out, 0);
    endtask

    task automatic t_timer_zero();
        do_reset();
        mode_sel = 3'b110;
        strobe(3, 65535);
        check("R2 zero preload pre", sq_out, 0);
        check("R2 zero count", count_val, 1);
        strobe(3, 1);
        check("R2 zero preload 65536", sq_out, 1);
    endtask

    task automatic t_timer_pin();
        do_reset();
        mode_sel = 3'b100;
        write_pre(16'd2);
        cmd(1, 0);
        strobe(0, 1); strobe(3, 3);
        check("R8 mode100 pin", count_val, 1);
        do_reset();
        mode_sel = 3'b101;
        write_pre(16'd2);
        cmd(1, 0);
        strobe(0, 15);
        check("R8 mode101 15", count_val, 2);
        strobe(0, 1);
        check("R8 R9 mode101 16th", count_val, 1);
        do_reset();
        mode_sel = 3'b111;
        write_pre(16'd2);
        cmd(1, 0);
        strobe(0, 16);
        strobe(3, 16);
        check("R8 mode111 xtal div", count_val, 1);
    endtask

    task automatic t_collide();
        do_reset();
        mode_sel = 3'b001;
        write_pre(16'd2);
        cmd(1, 0);
        strobe(1, 1);
        txa_stb = 1; stop_cmd = 1;
        @(negedge clk);
        txa_stb = 0; stop_cmd = 0;
        check("R5 stop vs terminal ready", ready, 0);
        check("R5 terminal count", count_val, 0);
        txa_stb = 1; start_cmd = 1;
        @(negedge clk);
        txa_stb = 0; start_cmd = 0;
        check("R10 start wins tick", count_val, 2);
        start_cmd = 1; stop_cmd = 1;
        @(negedge clk);
        start_cmd = 0; stop_cmd = 0;
        strobe(1, 1);
        check("R5 stop wins start", count_val, 2);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_counter_txa();
        t_counter_other();
        t_counter_xdiv();
        t_timer_xtal();
        t_timer_zero();
        t_timer_pin();
        t_collide();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule